// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Condition Flags

This block is the arithmetic and logic stage of a small 8-bit accumulator processor. Each clock it takes an operation code, the accumulator, a second operand and the four incoming condition flags. It produces the new accumulator value and the four new flags. The flags are zero, subtract, half carry and carry.

Every operation has a fixed rule for each flag: compute it from the result, force it to 0 or 1, or pass the incoming value through. The operations are binary add and subtract (each with and without the incoming carry), compare, bitwise AND, XOR and OR, and increment and decrement of the accumulator. There are also decimal adjust after BCD arithmetic, accumulator complement, and setting or inverting the carry.

The result and flags are registered. The values computed from the inputs sampled at one rising edge are on the outputs right after that edge. The instruction decoder feeds operands and flags, and the register file writes the outputs back.

Top module: `alu8_core`

## Requirements
- R1: While the active-low reset `rst_n` is 0, `res_q` and `flags_q` are 0 regardless of the other inputs.
- R2: Operation codes are ADD=0, ADC=1, SUB=2, SBC=3, AND=4, XOR=5, OR=6, CP=7, INC=8, DEC=9, DAA=10, CPL=11, SCF=12 and CCF=13. Flag vectors are {Z,N,H,C} with Z at bit 3 and C at bit 0. The outputs for the inputs sampled at a rising edge appear on `res_q`/`flags_q` right after that edge.
- R3: ADD returns A+B mod 256 and ADC returns A+B+Cin mod 256. Both give N=0, H = carry out of bit 3 of the low nibbles (including Cin for ADC), C = carry out of bit 7, and Z=1 exactly when the result is 0.
- R4: SUB returns A-B mod 256 and SBC returns A-B-Cin mod 256. Both give N=1, H = borrow into bit 4 (low nibble of A less than low nibble of B plus Cin for SBC), C = borrow out of bit 7, and Z from the result.
- R5: CP gives exactly the flags SUB would give, and returns A unchanged.
- R6: AND returns A&B with N=0, H=1, C=0 and Z from the result.
- R7: XOR and OR return A^B and A|B with N=H=C=0 and Z from the result.
- R8: INC and DEC return A+1 and A-1 mod 256 (B ignored). INC forces N=0, with H=1 when the low nibble of A is 0xF. DEC forces N=1, with H=1 when the low nibble of A is 0x0. Both compute Z and pass C through.
- R9: DAA with N=0 adds 0x60 when C=1 or A>0x99, and then sets C. It adds 0x06 when H=1 or the low nibble of A is above 9. With N=1 it subtracts 0x60 if C=1 and 0x06 if H=1, and keeps C. It passes N through, forces H=0 and computes Z.
- R10: CPL returns the bitwise inverse of A, forces N=H=1 and passes Z and C through.
- R11: SCF and CCF return A unchanged, force N=H=0 and pass Z through. SCF sets C=1 and CCF inverts C.
- R12: Codes 14 and 15 return A and the incoming flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second operand |
| flags_i | input | 4 | Incoming flags {Z,N,H,C} |
| res_q | output | 8 | Registered result |
| flags_q | output | 4 | Registered flags {Z,N,H,C} |

## Verification
Nothing persists from one operation to the next beyond the output register. A wrong operand route, nibble carry or flag rule therefore shows on `res_q` or `flags_q` one clock after the offending inputs are sampled. A fault limited to the nibble carry shows only in H, and only for operand pairs whose low nibbles just reach or miss the carry. For that reason every accumulator value is paired with boundary second operands and both values of the incoming carry. The decimal adjust paths are exposed by sweeping every accumulator value under every combination of the incoming flags.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int OP_W   = 4;
    localparam int FLAG_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_AND = 4'd4,
        OP_XOR = 4'd5,
        OP_OR  = 4'd6,
        OP_CP  = 4'd7,
        OP_INC = 4'd8,
        OP_DEC = 4'd9,
        OP_DAA = 4'd10,
        OP_CPL = 4'd11,
        OP_SCF = 4'd12,
        OP_CCF = 4'd13
    } alu_op_e;

    // Bit order matches the flag ports: z is the MSB, c the LSB.
    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        flags_t            fl;
    } alu_state_t;

    // Selects of the bitwise unit
    localparam logic [1:0] LG_AND = 2'd0;
    localparam logic [1:0] LG_XOR = 2'd1;
    localparam logic [1:0] LG_OR  = 2'd2;
    localparam logic [1:0] LG_INV = 2'd3;
endpackage

// File: rtl/alu8_addsub.sv
// Shared adder/subtractor with nibble and byte carry outputs.
// Subtraction is A + ~B + ~cin; carries are inverted into borrows.
module alu8_addsub #(
    parameter int W = alu8_pkg::DATA_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         half_o,
    output logic         carry_o
);
    localparam int NW = W / 2;

    logic [W-1:0] b_x;
    logic         cin_x;
    logic [NW:0]  lo_sum;
    logic [W:0]   full_sum;

    always_comb begin
        b_x      = sub_i ? ~b_i : b_i;
        cin_x    = sub_i ? ~cin_i : cin_i;
        lo_sum   = {1'b0, a_i[NW-1:0]} + {1'b0, b_x[NW-1:0]} + {{NW{1'b0}}, cin_x};
        full_sum = {1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, cin_x};
        sum_o    = full_sum[W-1:0];
        half_o   = lo_sum[NW] ^ sub_i;
        carry_o  = full_sum[W] ^ sub_i;
    end
endmodule

// File: rtl/alu8_logic.sv
// Bitwise unit: AND, XOR, OR and inversion of A.
module alu8_logic #(
    parameter int W = alu8_pkg::DATA_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   sel_i,
    output logic [W-1:0] res_o
);
    import alu8_pkg::*;

    always_comb begin
        case (sel_i)
            LG_AND:  res_o = a_i & b_i;
            LG_XOR:  res_o = a_i ^ b_i;
            LG_OR:   res_o = a_i | b_i;
            default: res_o = ~a_i;
        endcase
    end
endmodule

// File: rtl/alu8_daa.sv
// Decimal correction of the accumulator after packed-BCD add or subtract.
module alu8_daa #(
    parameter int W = alu8_pkg::DATA_W
) (
    input  logic [W-1:0] a_i,
    input  logic         n_i,
    input  logic         h_i,
    input  logic         c_i,
    output logic [W-1:0] res_o,
    output logic         c_o
);
    localparam int NW = W / 2;
    localparam logic [W-1:0] LO_FIX   = W'(6);
    localparam logic [W-1:0] HI_FIX   = W'(6) << NW;
    localparam logic [W-1:0] BYTE_MAX = (W'(9) << NW) | W'(9);
    localparam logic [NW-1:0] NIB_MAX = NW'(9);

    logic         need_hi;
    logic         need_lo;
    logic [W-1:0] fix;

    always_comb begin
        if (n_i) begin
            need_hi = c_i;
            need_lo = h_i;
        end else begin
            need_hi = c_i || (a_i > BYTE_MAX);
            need_lo = h_i || (a_i[NW-1:0] > NIB_MAX);
        end
        fix   = (need_hi ? HI_FIX : '0) | (need_lo ? LO_FIX : '0);
        res_o = n_i ? (a_i - fix) : (a_i + fix);
        c_o   = need_hi;
    end
endmodule

// File: rtl/alu8_core.sv
// Registered 8-bit accumulator ALU with per-operation flag rules.
module alu8_core #(
    parameter int DATA_W = alu8_pkg::DATA_W,
    parameter int OP_W   = alu8_pkg::OP_W,
    parameter int FLAG_W = alu8_pkg::FLAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [DATA_W-1:0] res_q,
    output logic [FLAG_W-1:0] flags_q
);
    import alu8_pkg::*;

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    flags_t            fin;
    logic [DATA_W-1:0] ar_b;
    logic              ar_cin;
    logic              ar_sub;
    logic [DATA_W-1:0] ar_sum;
    logic              ar_half;
    logic              ar_carry;
    logic [1:0]        lg_sel;
    logic [DATA_W-1:0] lg_res;
    logic [DATA_W-1:0] dj_res;
    logic              dj_carry;
    alu_state_t        state_d;
    alu_state_t        state_q;

    assign fin = flags_t'(flags_i);

    // Operand steering for the shared units
    always_comb begin
        ar_b   = b_i;
        ar_cin = 1'b0;
        ar_sub = 1'b0;
        lg_sel = LG_AND;
        case (op_i)
            OP_ADC: ar_cin = fin.c;
            OP_SUB: ar_sub = 1'b1;
            OP_CP:  ar_sub = 1'b1;
            OP_SBC: begin
                ar_sub = 1'b1;
                ar_cin = fin.c;
            end
            OP_INC: ar_b = ONE;
            OP_DEC: begin
                ar_b   = ONE;
                ar_sub = 1'b1;
            end
            OP_XOR: lg_sel = LG_XOR;
            OP_OR:  lg_sel = LG_OR;
            OP_CPL: lg_sel = LG_INV;
            default: ;
        endcase
    end

    alu8_addsub #(.W(DATA_W)) u_addsub (
        .a_i     (a_i),
        .b_i     (ar_b),
        .cin_i   (ar_cin),
        .sub_i   (ar_sub),
        .sum_o   (ar_sum),
        .half_o  (ar_half),
        .carry_o (ar_carry)
    );

    alu8_logic #(.W(DATA_W)) u_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .sel_i (lg_sel),
        .res_o (lg_res)
    );

    alu8_daa #(.W(DATA_W)) u_daa (
        .a_i   (a_i),
        .n_i   (fin.n),
        .h_i   (fin.h),
        .c_i   (fin.c),
        .res_o (dj_res),
        .c_o   (dj_carry)
    );

    // Result and flag selection
    always_comb begin
        state_d.res = a_i;
        state_d.fl  = fin;
        case (op_i)
            OP_ADD, OP_ADC: begin
                state_d.res = ar_sum;
                state_d.fl  = '{z: (ar_sum == '0), n: 1'b0, h: ar_half, c: ar_carry};
            end
            OP_SUB, OP_SBC: begin
                state_d.res = ar_sum;
                state_d.fl  = '{z: (ar_sum == '0), n: 1'b1, h: ar_half, c: ar_carry};
            end
            OP_CP: begin
                state_d.fl  = '{z: (ar_sum == '0), n: 1'b1, h: ar_half, c: ar_carry};
            end
            OP_AND: begin
                state_d.res = lg_res;
                state_d.fl  = '{z: (lg_res == '0), n: 1'b0, h: 1'b1, c: 1'b0};
            end
            OP_XOR, OP_OR: begin
                state_d.res = lg_res;
                state_d.fl  = '{z: (lg_res == '0), n: 1'b0, h: 1'b0, c: 1'b0};
            end
            OP_INC: begin
                state_d.res = ar_sum;
                state_d.fl  = '{z: (ar_sum == '0), n: 1'b0, h: ar_half, c: fin.c};
            end
            OP_DEC: begin
                state_d.res = ar_sum;
                state_d.fl  = '{z: (ar_sum == '0), n: 1'b1, h: ar_half, c: fin.c};
            end
            OP_DAA: begin
                state_d.res = dj_res;
                state_d.fl  = '{z: (dj_res == '0), n: fin.n, h: 1'b0, c: dj_carry};
            end
            OP_CPL: begin
                state_d.res = lg_res;
                state_d.fl  = '{z: fin.z, n: 1'b1, h: 1'b1, c: fin.c};
            end
            OP_SCF: state_d.fl = '{z: fin.z, n: 1'b0, h: 1'b0, c: 1'b1};
            OP_CCF: state_d.fl = '{z: fin.z, n: 1'b0, h: 1'b0, c: ~fin.c};
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign res_q   = state_q.res;
    assign flags_q = state_q.fl;

    // R3: additions clear N and report Z from the registered result
    a_r3_add_n_z: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ADD || op_i == OP_ADC) |=> (!flags_q[2] && (flags_q[3] == (res_q == '0))));

    // R5: compare never alters the accumulator
    a_r5_cp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CP) |=> (res_q == $past(a_i) && flags_q[2]));

    // R6: AND flag pattern
    a_r6_and_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_AND) |=> (flags_q[1] && !flags_q[2] && !flags_q[0]));

    // R7: XOR/OR clear N, H, C
    a_r7_logic_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_XOR || op_i == OP_OR) |=> (flags_q[2:0] == 3'b000 && flags_q[3] == (res_q == '0)));

    // R8: increment/decrement preserve the carry
    a_r8_incdec_keep_c: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_INC || op_i == OP_DEC) |=> (flags_q[0] == $past(flags_i[0])));

    // R9: decimal adjust clears H and keeps N
    a_r9_daa_hn: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_DAA) |=> (!flags_q[1] && flags_q[2] == $past(flags_i[2])));

    // R10: complement inverts A and keeps Z, C
    a_r10_cpl: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CPL) |=> (res_q == ~$past(a_i) && flags_q[3] == $past(flags_i[3])
                              && flags_q[0] == $past(flags_i[0])));

    // R11: carry set/complement
    a_r11_carry_ops: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SCF || op_i == OP_CCF) |=> (res_q == $past(a_i) && flags_q[2:1] == 2'b00
            && flags_q[0] == ($past(op_i) == OP_SCF ? 1'b1 : ~$past(flags_i[0]))));

    // R12: unassigned codes pass everything through
    a_r12_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > OP_CCF) |=> (res_q == $past(a_i) && flags_q == $past(flags_i)));
endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = 4'd0;
    logic [7:0] a_i = 8'd0;
    logic [7:0] b_i = 8'd0;
    logic [3:0] flags_i = 4'd0;
    logic [7:0] res_q;
    logic [3:0] flags_q;

    int checks = 0;
    int errors = 0;
    bit pend = 1'b0;
    bit done = 1'b0;
    int exp_res;
    int exp_fl;
    int exp_op;

    always #10 clk = ~clk;

    alu8_core u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (op_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .flags_i (flags_i),
        .res_q   (res_q),
        .flags_q (flags_q)
    );

    function automatic string tag(int op);
        case (op)
            0, 1:    return "R2 R3";
            2, 3:    return "R2 R4";
            7:       return "R2 R5";
            4:       return "R2 R6";
            5, 6:    return "R2 R7";
            8, 9:    return "R2 R8";
            10:      return "R2 R9";
            11:      return "R2 R10";
            12, 13:  return "R2 R11";
            default: return "R2 R12";
        endcase
    endfunction

    function automatic int bval(int k);
        case (k)
            0: return 8'h00;  1: return 8'h01;  2: return 8'h0F;  3: return 8'h10;
            4: return 8'h1F;  5: return 8'h7F;  6: return 8'h80;  7: return 8'h81;
            8: return 8'h99;  9: return 8'hF0; 10: return 8'hFF; 11: return 8'h0E;
           12: return 8'h55; 13: return 8'hAA; 14: return 8'h3C; default: return 8'hC3;
        endcase
    endfunction

    // Reference model: returns {result, Z, N, H, C}
    function automatic int model(int op, int a, int b, int f);
        int z = (f >> 3) & 1;
        int n = (f >> 2) & 1;
        int h = (f >> 1) & 1;
        int c = f & 1;
        int r = a;
        int ci, s, adj;
        case (op)
            0, 1: begin
                ci = (op == 1) ? c : 0;
                s = a + b + ci;
                r = s % 256;
                h = ((a % 16) + (b % 16) + ci > 15) ? 1 : 0;
                c = (s > 255) ? 1 : 0;
                n = 0;
                z = (r == 0) ? 1 : 0;
            end
            2, 3, 7: begin
                ci = (op == 3) ? c : 0;
                r = (a - b - ci + 512) % 256;
                h = ((a % 16) < (b % 16) + ci) ? 1 : 0;
                c = (a < b + ci) ? 1 : 0;
                n = 1;
                z = (r == 0) ? 1 : 0;
                if (op == 7) r = a;
            end
            4: begin r = a & b; z = (r == 0); n = 0; h = 1; c = 0; end
            5: begin r = a ^ b; z = (r == 0); n = 0; h = 0; c = 0; end
            6: begin r = a | b; z = (r == 0); n = 0; h = 0; c = 0; end
            8: begin r = (a + 1) % 256; h = (a % 16 == 15); n = 0; z = (r == 0); end
            9: begin r = (a + 255) % 256; h = (a % 16 == 0); n = 1; z = (r == 0); end
            10: begin
                adj = 0;
                if (n == 0) begin
                    if (c == 1 || a > 153) begin adj += 96; c = 1; end
                    if (h == 1 || a % 16 > 9) adj += 6;
                    r = (a + adj) % 256;
                end else begin
                    if (c == 1) adj += 96;
                    if (h == 1) adj += 6;
                    r = (a - adj + 256) % 256;
                end
                h = 0;
                z = (r == 0);
            end
            11: begin r = 255 - a; n = 1; h = 1; end
            12: begin c = 1; n = 0; h = 0; end
            13: begin c = 1 - c; n = 0; h = 0; end
            default: ;
        endcase
        return (r << 4) | (z << 3) | (n << 2) | (h << 1) | c;
    endfunction

    task automatic check_out();
        checks++;
        if (res_q !== 8'(exp_res) || flags_q !== 4'(exp_fl)) begin
            errors++;
            $display("FAIL %s op=%0d a=%02h b=%02h f=%h: got res=%02h fl=%h expected res=%02h fl=%h",
                     tag(exp_op), exp_op, a_i, b_i, flags_i, res_q, flags_q, exp_res, exp_fl);
        end
    endtask

    // Drive one vector on a falling edge; check the previous one there too
    task automatic push(int op, int a, int b, int f);
        int m;
        @(negedge clk);
        if (pend) check_out();
        op_i    = 4'(op);
        a_i     = 8'(a);
        b_i     = 8'(b);
        flags_i = 4'(f);
        m       = model(op, a, b, f);
        exp_res = m >> 4;
        exp_fl  = m & 15;
        exp_op  = op;
        pend    = 1'b1;
    endtask

    initial begin
        // R1: outputs held at zero during reset with busy inputs
        op_i = 4'd11; a_i = 8'h5A; b_i = 8'hFF; flags_i = 4'hF;
        repeat (3) @(negedge clk);
        checks++;
        if (res_q !== 8'h00 || flags_q !== 4'h0) begin
            errors++;
            $display("FAIL R1 reset: got res=%02h fl=%h expected res=00 fl=0", res_q, flags_q);
        end
        rst_n = 1'b1;

        // R3 R4 R5: arithmetic and compare, both incoming carries
        for (int op = 0; op < 8; op++) begin
            if (op >= 4 && op <= 6) continue;
            for (int a = 0; a < 256; a++)
                for (int k = 0; k < 16; k++)
                    for (int cb = 0; cb < 2; cb++)
                        push(op, a, bval(k), ((a >> 7) << 3) | ((a & 1) << 2) | (((k >> 1) & 1) << 1) | cb);
        end

        // R6 R7: bitwise operations
        for (int op = 4; op < 7; op++)
            for (int a = 0; a < 256; a++)
                for (int k = 0; k < 16; k++)
                    push(op, a, bval(k), k);

        // R8 R9 R10 R11: single-operand ops under every flag combination
        for (int op = 8; op < 14; op++)
            for (int a = 0; a < 256; a++)
                for (int f = 0; f < 16; f++)
                    push(op, a, (a * 7) % 256, f);

        // R12: unassigned codes
        for (int op = 14; op < 16; op++)
            for (int a = 0; a < 256; a++)
                push(op, a, 255 - a, a % 16);

        @(negedge clk);
        if (pend) check_out();
        pend = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got no completion expected completion within 190000 cycles");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule